// File: doc/BRIEF.md
# Card Controller Host Register Block

This block is the processor-facing side of a memory card controller. A single-cycle read/write port with a 12-bit byte address reaches power and clock-divider settings, the command argument and command word, data timeout, transfer length and data control, four response words, the live byte counter, a status word with a write-one-to-clear companion, two interrupt masks, a rounded word count, a sixteen-word window onto the data FIFO and eight identification bytes. Read data is combinational in the access cycle; every side effect of an access lands on the clock edge that ends it.

Status combines eleven sticky event bits, set by one-cycle pulses from the command and data engines, with eleven level flags that mirror the FIFO state. Each of the two interrupt lines is the registered OR of status ANDed with its own mask. Issuing a command or enabling the data path gives a one-cycle start pulse toward the engine concerned.

A small two-state machine makes the refill hold. In state RUN the data engine may move words; the transition RUN to PAUSED is taken when the host pops a word through the FIFO window. In PAUSED the engine is held, and the transition PAUSED to RUN is taken when the host reads the status word or the word count. A further pop while in PAUSED keeps the machine in PAUSED. The value returned by the releasing read is the one present before the release.

Top module: `card_host_regs`

## Requirements
- R1: After reset every register, both masks and the event status bits read zero, both interrupt lines are low, the hold is released and no start pulse is present.
- R2: Power (0x00) and clock (0x04) keep write bits [7:0], data length (0x28) keeps [15:0], data control (0x2C) keeps [7:0]; argument (0x08) and data timer (0x24) keep all 32 bits.
- R3: A command write (0x0C) is stored with bit 10 forced to zero; when the written bit 10 is one, cmd_start is high for exactly the one cycle after the write edge.
- R4: A data control write with bit 0 set makes eng_start high for exactly the one cycle after the write edge; with bit 0 clear no pulse appears.
- R5: Status (0x34) bits [10:0] are set by ev_set pulses and stay set; bits [21:11] show fifo_flags[10:0] live; bits [31:22] read zero.
- R6: A write to the clear register (0x38) clears status bits [10:0] that are one in the written value; bits [21:11] are unaffected; an ev_set pulse in the same cycle wins over the clear; the clear register reads zero.
- R7: irq[i] equals the OR of (status AND mask i), with mask 0 at 0x3C and mask 1 at 0x40, and follows a change one cycle later.
- R8: A read anywhere in 0x80 to 0xBC returns fifo_rdata and raises fifo_pop in that cycle when fifo_empty is low; when fifo_empty is high it returns zero and no pop occurs.
- R9: A write anywhere in 0x80 to 0xBC raises fifo_push with fifo_push_data equal to the written word when eng_bytes_left is nonzero; when it is zero no push occurs.
- R10: A popping read moves the hold machine from RUN to PAUSED, so eng_hold is high from the next cycle; a read of 0x34 or 0x48 returns its value and moves it back to RUN; reads of other registers leave the hold in place.
- R11: 0x30 returns eng_bytes_left and 0x48 returns (eng_bytes_left + 3) / 4 rounded down.
- R12: Reads of 0xFE0, 0xFE4 up to 0xFFC return 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order; 0x14, 0x18, 0x1C and 0x20 return response words 0 to 3, loaded from rsp_words (word 0 in bits [31:0]) on rsp_load.
- R13: Offsets not listed above, including any address with nonzero bits [1:0], read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 2 | Masked status interrupt lines |
| pwr_ctl | output | 8 | Power setting |
| clk_ctl | output | 8 | Card clock setting |
| cmd_arg | output | 32 | Command argument |
| cmd_word | output | 32 | Stored command word |
| data_timer | output | 32 | Data timeout |
| data_len | output | 16 | Transfer length in bytes |
| data_ctl | output | 8 | Data control |
| cmd_start | output | 1 | One-cycle command issue pulse |
| eng_start | output | 1 | One-cycle data engine start pulse |
| eng_hold | output | 1 | Pause request to the data engine |
| eng_bytes_left | input | 16 | Remaining byte count from the engine |
| ev_set | input | 11 | Event status set pulses |
| fifo_flags | input | 11 | Level FIFO status flags |
| rsp_load | input | 1 | Capture response words |
| rsp_words | input | 128 | Four response words |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_pop | output | 1 | Pop the FIFO head this cycle |
| fifo_push | output | 1 | Push a word this cycle |
| fifo_push_data | output | 32 | Word to push |

## Verification
Read data, fifo_pop, fifo_push and the level half of status are due within the access cycle, so the bench samples them one nanosecond after the falling edge that presents the access, before the rising edge that commits it. Stored registers, sticky event bits, start pulses and the hold state change on that rising edge and are checked at the next falling edge, while an interrupt line follows status one edge later, so its checks look first for the unchanged value and then for the new one a cycle after. Release of the hold is checked at the falling edge after the releasing read, with the read value itself sampled before that edge.

// File: rtl/chr_pkg.sv
`timescale 1ns/1ps
package chr_pkg;
    localparam int ADDR_W   = 12;
    localparam int IRQ_N    = 2;
    localparam int RSP_N    = 4;
    localparam int WIN_BASE = 'h080;
    localparam int WIN_LEN  = 16;
    localparam int ID_BASE  = 'hFE0;
    localparam int ID_LEN   = 8;

    typedef enum logic [4:0] {
        RG_NONE, RG_PWR, RG_CLK, RG_ARG, RG_CMD, RG_RSP, RG_TMR, RG_LEN,
        RG_DCTL, RG_DCNT, RG_STAT, RG_CLR, RG_MSK0, RG_MSK1, RG_FCNT,
        RG_FIFO, RG_ID
    } reg_sel_e;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h81;
            3'd1: b = 8'h11;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/chr_addr_decode.sv
`timescale 1ns/1ps
module chr_addr_decode
    import chr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + 4 * WIN_LEN);
    localparam logic [ADDR_W-1:0] ID_LO  = ADDR_W'(ID_BASE);
    localparam logic [ADDR_W:0]   ID_HI  = (ADDR_W+1)'(ID_BASE + 4 * ID_LEN);

    always_comb begin
        sel = RG_NONE;
        if (addr[1:0] != 2'b00) begin
            sel = RG_NONE;
        end else if (addr >= WIN_LO && addr < WIN_HI) begin
            sel = RG_FIFO;
        end else if (addr >= ID_LO && {1'b0, addr} < ID_HI) begin
            sel = RG_ID;
        end else begin
            unique case (addr)
                12'h000: sel = RG_PWR;
                12'h004: sel = RG_CLK;
                12'h008: sel = RG_ARG;
                12'h00C: sel = RG_CMD;
                12'h014, 12'h018, 12'h01C, 12'h020: sel = RG_RSP;
                12'h024: sel = RG_TMR;
                12'h028: sel = RG_LEN;
                12'h02C: sel = RG_DCTL;
                12'h030: sel = RG_DCNT;
                12'h034: sel = RG_STAT;
                12'h038: sel = RG_CLR;
                12'h03C: sel = RG_MSK0;
                12'h040: sel = RG_MSK1;
                12'h048: sel = RG_FCNT;
                default: sel = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/chr_status_irq.sv
`timescale 1ns/1ps
module chr_status_irq
    import chr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EV_W   = 11,
    parameter int LV_W   = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [EV_W-1:0]              ev_set_i,
    input  logic [LV_W-1:0]              lv_flags_i,
    input  logic                         clr_we_i,
    input  logic [EV_W-1:0]              clr_bits_i,
    input  logic [IRQ_N-1:0]             msk_we_i,
    input  logic [DATA_W-1:0]            msk_data_i,
    output logic [DATA_W-1:0]            status_o,
    output logic [IRQ_N-1:0][DATA_W-1:0] mask_o,
    output logic [IRQ_N-1:0]             irq_o
);
    localparam int ST_W = EV_W + LV_W;

    logic [EV_W-1:0] ev_q;
    logic [EV_W-1:0] clr_mask;

    assign clr_mask = clr_we_i ? clr_bits_i : '0;
    assign status_o = DATA_W'({lv_flags_i, ev_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~clr_mask) | ev_set_i;
    end

    // R5: sticky bits only fall through a clear write
    a_r5_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

    for (genvar i = 0; i < IRQ_N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[i] <= '0;
                irq_o[i]  <= 1'b0;
            end else begin
                if (msk_we_i[i]) mask_o[i] <= msk_data_i;
                irq_o[i] <= |(status_o[ST_W-1:0] & mask_o[i][ST_W-1:0]);
            end
        end

        // R7: line follows masked status one cycle later
        a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[i] == $past(|(status_o[ST_W-1:0] & mask_o[i][ST_W-1:0])));
    end
endmodule

// File: rtl/chr_hold_fsm.sv
`timescale 1ns/1ps
module chr_hold_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pop_i,
    input  logic poll_i,
    output logic hold_o
);
    typedef enum logic [0:0] { HOLD_RUN, HOLD_PAUSED } hold_state_e;

    hold_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_RUN:    if (pop_i) state_d = HOLD_PAUSED;
            HOLD_PAUSED: if (poll_i && !pop_i) state_d = HOLD_RUN;
            default:     state_d = HOLD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        hold_o = (state_q == HOLD_PAUSED);
    end

    // R10: pause only ever follows a pop
    a_r10_pause_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(pop_i));
    // R10: a poll without a pop releases the engine
    a_r10_poll_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && poll_i && !pop_i) |=> !hold_o);
endmodule

// File: rtl/card_host_regs.sv
`timescale 1ns/1ps
module card_host_regs
    import chr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NARROW_W   = 8,
    parameter int LEN_W      = 16,
    parameter int EV_W       = 11,
    parameter int LV_W       = 11,
    parameter int CMD_EN_BIT = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [IRQ_N-1:0]        irq,
    output logic [NARROW_W-1:0]     pwr_ctl,
    output logic [NARROW_W-1:0]     clk_ctl,
    output logic [DATA_W-1:0]       cmd_arg,
    output logic [DATA_W-1:0]       cmd_word,
    output logic [DATA_W-1:0]       data_timer,
    output logic [LEN_W-1:0]        data_len,
    output logic [NARROW_W-1:0]     data_ctl,
    output logic                    cmd_start,
    output logic                    eng_start,
    output logic                    eng_hold,
    input  logic [LEN_W-1:0]        eng_bytes_left,
    input  logic [EV_W-1:0]         ev_set,
    input  logic [LV_W-1:0]         fifo_flags,
    input  logic                    rsp_load,
    input  logic [RSP_N*DATA_W-1:0] rsp_words,
    input  logic                    fifo_empty,
    input  logic [DATA_W-1:0]       fifo_rdata,
    output logic                    fifo_pop,
    output logic                    fifo_push,
    output logic [DATA_W-1:0]       fifo_push_data
);
    localparam int RSP_IW = $clog2(RSP_N);
    localparam logic [RSP_IW-1:0] RSP_ROT = RSP_IW'(3);

    reg_sel_e                      sel;
    logic                          wr_acc, rd_acc;
    logic [DATA_W-1:0]             status;
    logic [IRQ_N-1:0][DATA_W-1:0]  mask;
    logic [DATA_W-1:0]             rsp_q [RSP_N];
    logic [RSP_IW-1:0]             rsp_idx;
    logic [LEN_W:0]                word_cnt;
    logic                          poll;

    assign wr_acc = bus_sel &&  bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    chr_addr_decode u_dec (.addr(bus_addr), .sel(sel));

    chr_status_irq #(.DATA_W(DATA_W), .EV_W(EV_W), .LV_W(LV_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_set_i   (ev_set),
        .lv_flags_i (fifo_flags),
        .clr_we_i   (wr_acc && sel == RG_CLR),
        .clr_bits_i (bus_wdata[EV_W-1:0]),
        .msk_we_i   ({wr_acc && sel == RG_MSK1, wr_acc && sel == RG_MSK0}),
        .msk_data_i (bus_wdata),
        .status_o   (status),
        .mask_o     (mask),
        .irq_o      (irq)
    );

    assign fifo_pop       = rd_acc && sel == RG_FIFO && !fifo_empty;
    assign fifo_push      = wr_acc && sel == RG_FIFO && eng_bytes_left != '0;
    assign fifo_push_data = bus_wdata;
    assign poll           = rd_acc && (sel == RG_STAT || sel == RG_FCNT);

    chr_hold_fsm u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop_i  (fifo_pop),
        .poll_i (poll),
        .hold_o (eng_hold)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_ctl    <= '0;
            clk_ctl    <= '0;
            cmd_arg    <= '0;
            cmd_word   <= '0;
            data_timer <= '0;
            data_len   <= '0;
            data_ctl   <= '0;
            cmd_start  <= 1'b0;
            eng_start  <= 1'b0;
        end else begin
            cmd_start <= 1'b0;
            eng_start <= 1'b0;
            if (wr_acc) begin
                unique case (sel)
                    RG_PWR: pwr_ctl    <= bus_wdata[NARROW_W-1:0];
                    RG_CLK: clk_ctl    <= bus_wdata[NARROW_W-1:0];
                    RG_ARG: cmd_arg    <= bus_wdata;
                    RG_TMR: data_timer <= bus_wdata;
                    RG_LEN: data_len   <= bus_wdata[LEN_W-1:0];
                    RG_CMD: begin
                        cmd_word  <= bus_wdata & ~(DATA_W'(1) << CMD_EN_BIT);
                        cmd_start <= bus_wdata[CMD_EN_BIT];
                    end
                    RG_DCTL: begin
                        data_ctl  <= bus_wdata[NARROW_W-1:0];
                        eng_start <= bus_wdata[0];
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar k = 0; k < RSP_N; k++) begin : g_rsp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        rsp_q[k] <= '0;
            else if (rsp_load) rsp_q[k] <= rsp_words[k*DATA_W +: DATA_W];
        end
    end

    assign rsp_idx  = bus_addr[RSP_IW+1:2] + RSP_ROT;
    assign word_cnt = ({1'b0, eng_bytes_left} + (LEN_W+1)'(3)) >> 2;

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            RG_PWR:  bus_rdata = DATA_W'(pwr_ctl);
            RG_CLK:  bus_rdata = DATA_W'(clk_ctl);
            RG_ARG:  bus_rdata = cmd_arg;
            RG_CMD:  bus_rdata = cmd_word;
            RG_RSP:  bus_rdata = rsp_q[rsp_idx];
            RG_TMR:  bus_rdata = data_timer;
            RG_LEN:  bus_rdata = DATA_W'(data_len);
            RG_DCTL: bus_rdata = DATA_W'(data_ctl);
            RG_DCNT: bus_rdata = DATA_W'(eng_bytes_left);
            RG_STAT: bus_rdata = status;
            RG_MSK0: bus_rdata = mask[0];
            RG_MSK1: bus_rdata = mask[1];
            RG_FCNT: bus_rdata = DATA_W'(word_cnt);
            RG_FIFO: bus_rdata = fifo_empty ? '0 : fifo_rdata;
            RG_ID:   bus_rdata = DATA_W'(ident_byte(bus_addr[4:2]));
            default: bus_rdata = '0;
        endcase
    end

    // R3: the stored command never keeps its issue bit
    a_r3_issue_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_word[CMD_EN_BIT]);
    // R8: no pop from an empty FIFO
    a_r8_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);
    // R9: no push once the byte counter is exhausted
    a_r9_no_idle_push: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> eng_bytes_left != '0);
endmodule

// File: tb/tb_card_host_regs.sv
`timescale 1ns/1ps
module tb_card_host_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [1:0]   irq;
    logic [7:0]   pwr_ctl, clk_ctl, data_ctl;
    logic [31:0]  cmd_arg, cmd_word, data_timer;
    logic [15:0]  data_len;
    logic         cmd_start, eng_start, eng_hold;
    logic [15:0]  eng_bytes_left = '0;
    logic [10:0]  ev_set = '0, fifo_flags = '0;
    logic         rsp_load = 1'b0;
    logic [127:0] rsp_words = '0;
    logic         fifo_empty = 1'b1;
    logic [31:0]  fifo_rdata = '0;
    logic         fifo_pop, fifo_push;
    logic [31:0]  fifo_push_data;

    int checks = 0, errors = 0;
    logic        last_pop, last_push;
    logic [31:0] last_push_data;

    always #4 clk = ~clk;

    card_host_regs dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        last_push = fifo_push; last_push_data = fifo_push_data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; last_pop = fifo_pop;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_ev(input logic [10:0] bits);
        @(negedge clk); ev_set = bits;
        @(negedge clk); ev_set = '0;
    endtask

    // {req, addr, write data, expected readback}
    localparam int NV = 15;
    localparam logic [79:0] VEC [NV] = '{
        {4'd2,  12'h000, 32'hFFFF_FF5A, 32'h0000_005A},
        {4'd2,  12'h004, 32'h1234_56A5, 32'h0000_00A5},
        {4'd2,  12'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {4'd2,  12'h024, 32'h0BAD_F00D, 32'h0BAD_F00D},
        {4'd2,  12'h028, 32'hABCD_1234, 32'h0000_1234},
        {4'd2,  12'h02C, 32'h0000_01FE, 32'h0000_00FE},
        {4'd3,  12'h00C, 32'h0000_0245, 32'h0000_0245},
        {4'd7,  12'h03C, 32'h0000_0008, 32'h0000_0008},
        {4'd7,  12'h040, 32'h0000_1000, 32'h0000_1000},
        {4'd6,  12'h038, 32'h0000_0000, 32'h0000_0000},
        {4'd13, 12'h010, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'd13, 12'h044, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'd13, 12'h002, 32'h1234_5678, 32'h0000_0000},
        {4'd13, 12'h7FC, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'd13, 12'h0C0, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    localparam logic [7:0] ID_EXP [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(irq == 2'b00 && !eng_hold && !cmd_start && !eng_start, "R1", {28'd0, irq, eng_hold, cmd_start}, 32'd0);
        bus_read(12'h000, d); check(d == 0, "R1", d, 0);
        bus_read(12'h00C, d); check(d == 0, "R1", d, 0);
        bus_read(12'h034, d); check(d == 0, "R1", d, 0);
        bus_read(12'h03C, d); check(d == 0, "R1", d, 0);
        bus_read(12'h040, d); check(d == 0, "R1", d, 0);
        bus_read(12'h020, d); check(d == 0, "R1", d, 0);

        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            v = VEC[i];
            bus_write(v[75:64], v[63:32]);
            bus_read(v[75:64], d);
            check(d == v[31:0], $sformatf("R%0d vector %0d", v[79:76], i), d, v[31:0]);
        end
        // R2 outputs and R13 stray write left power untouched
        check(data_len == 16'h1234 && data_ctl == 8'hFE, "R2", {data_len, 8'h0, data_ctl}, 32'h1234_00FE);
        bus_read(12'h000, d); check(d == 32'h5A, "R13", d, 32'h5A);

        // R4: no start pulse without enable bit
        bus_write(12'h02C, 32'h0000_00FE);
        check(!eng_start, "R4", {31'd0, eng_start}, 0);
        bus_write(12'h02C, 32'h0000_0003);
        check(eng_start, "R4", {31'd0, eng_start}, 1);
        @(negedge clk); check(!eng_start, "R4", {31'd0, eng_start}, 0);

        // R3: issue pulse and stored word
        bus_write(12'h00C, 32'h0000_0411);
        check(cmd_start, "R3", {31'd0, cmd_start}, 1);
        @(negedge clk); check(!cmd_start, "R3", {31'd0, cmd_start}, 0);
        bus_read(12'h00C, d); check(d == 32'h0000_0011, "R3", d, 32'h11);

        // R5 / R7: event sets status, line one cycle later
        pulse_ev(11'h008);
        check(irq[0] == 1'b0, "R7", {31'd0, irq[0]}, 0);
        @(negedge clk);
        check(irq == 2'b01, "R7", {30'd0, irq}, 1);
        fifo_flags = 11'h002;
        @(negedge clk);
        check(irq == 2'b11, "R7", {30'd0, irq}, 3);
        bus_read(12'h034, d); check(d == 32'h0000_1008, "R5", d, 32'h1008);

        // R6: clear low bits only, set wins
        fifo_flags = 11'h5A5;
        pulse_ev(11'h7FF);
        bus_read(12'h034, d); check(d == 32'h002D_2FFF, "R5", d, 32'h002D_2FFF);
        bus_write(12'h038, 32'hFFFF_F00F);
        bus_read(12'h034, d); check(d == 32'h002D_2FF0, "R6", d, 32'h002D_2FF0);
        @(negedge clk);
        ev_set = 11'h001; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h1;
        @(negedge clk);
        ev_set = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(12'h034, d); check(d == 32'h002D_2FF1, "R6", d, 32'h002D_2FF1);
        fifo_flags = '0;
        bus_write(12'h038, 32'h0000_07FF);
        bus_read(12'h034, d); check(d == 0, "R6", d, 0);
        @(negedge clk);
        check(irq == 2'b00, "R7", {30'd0, irq}, 0);

        // R8 / R10: pop, hold, release by poll
        fifo_empty = 1'b0; fifo_rdata = 32'hCAFE_0001; eng_bytes_left = 16'd9;
        bus_read(12'h084, d);
        check(d == 32'hCAFE_0001 && last_pop, "R8", d, 32'hCAFE_0001);
        check(eng_hold, "R10", {31'd0, eng_hold}, 1);
        bus_read(12'h030, d); check(d == 32'd9, "R11", d, 9);
        check(eng_hold, "R10", {31'd0, eng_hold}, 1);
        bus_read(12'h048, d); check(d == 32'd3, "R10", d, 3);
        check(!eng_hold, "R10", {31'd0, eng_hold}, 0);
        bus_read(12'h0BC, d); check(last_pop && eng_hold, "R10", {30'd0, last_pop, eng_hold}, 3);
        bus_read(12'h034, d); check(d == 0, "R10", d, 0);
        check(!eng_hold, "R10", {31'd0, eng_hold}, 0);
        fifo_empty = 1'b1;
        bus_read(12'h080, d);
        check(d == 0 && !last_pop && !eng_hold, "R8", {d[29:0], last_pop, eng_hold}, 0);

        // R11: rounded word count
        eng_bytes_left = 16'd0;    bus_read(12'h048, d); check(d == 0, "R11", d, 0);
        eng_bytes_left = 16'd4;    bus_read(12'h048, d); check(d == 1, "R11", d, 1);
        eng_bytes_left = 16'd5;    bus_read(12'h048, d); check(d == 2, "R11", d, 2);
        eng_bytes_left = 16'hFFFF; bus_read(12'h048, d); check(d == 32'h4000, "R11", d, 32'h4000);
        bus_read(12'h030, d); check(d == 32'hFFFF, "R11", d, 32'hFFFF);

        // R9: push gated by the byte counter
        eng_bytes_left = 16'd0;
        bus_write(12'h080, 32'h1122_3344);
        check(!last_push, "R9", {31'd0, last_push}, 0);
        eng_bytes_left = 16'd5;
        bus_write(12'h0A0, 32'h5566_7788);
        check(last_push && last_push_data == 32'h5566_7788, "R9", last_push_data, 32'h5566_7788);

        // R12: identification and response words
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(4 * i), d);
            check(d == {24'd0, ID_EXP[i]}, "R12", d, {24'd0, ID_EXP[i]});
        end
        rsp_words = {32'h3333_0003, 32'h2222_0002, 32'h1111_0001, 32'h0000_AAA0};
        @(negedge clk); rsp_load = 1'b1;
        @(negedge clk); rsp_load = 1'b0;
        for (int i = 0; i < 4; i++) begin
            bus_read(12'h014 + 12'(4 * i), d);
            check(d == rsp_words[32*i +: 32], "R12", d, rsp_words[32*i +: 32]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule